// File: doc/BRIEF.md
# Video Presence Loss Detector

This block decides whether a live video signal is reaching the decoder. It receives one-cycle pulses from an upstream sync detector, one for every horizontal sync found and one for every vertical sync found, and runs a line-period timer from the most recent horizontal sync. When a fixed run of line periods passes with no horizontal sync, the block declares the signal absent. It then paces downstream logic with its own nominal line pulses at the line length of the selected standard.

A horizontal sync that arrives after a loss restores the present status at once. Two events are latched as sticky status bits: the drop from present to absent, and each vertical sync. Each bit has a fixed enable position in a mask input. The interrupt request is raised while any enabled status bit is set. Software clears status bits by writing ones to a clear input.

Top module: `vid_presence_det`

## Requirements
- R1: After reset, `video_present` is 0, `irq_status` is 0, `irq_req` is 0 and `freerun_line` is 0.
- R2: An `hsync_det` pulse sampled at a clock edge makes `video_present` 1 after that edge and restarts the line timer and the missed-line count.
- R3: While present, the signal is declared absent (`video_present` falls) after exactly 16 line lengths of clock edges with no `hsync_det`, counted from the edge that sampled the last pulse. An hsync arriving on the last of those edges keeps the signal present.
- R4: The line length is 858 clocks when `std_sel` is 0 (525-line standard) and 864 clocks when `std_sel` is 1 (625-line standard).
- R5: While absent, `freerun_line` is high for one cycle every line length. The first pulse comes in the cycle in which `video_present` falls. It never pulses while `video_present` is 1.
- R6: Status bit 6 (no-video) is set only by a transition from present to absent. Idling absent after reset, or staying absent for further lines, does not set it again.
- R7: An `vsync_det` pulse sets status bit 0 (vertical sync) after the edge that samples it.
- R8: `irq_req` is 1 exactly when some status bit is set and the same bit of `irq_mask` is 1. Bit 6 enables the no-video interrupt and bit 0 enables the vertical-sync interrupt.
- R9: Writing a 1 to a bit of `irq_clr` clears that status bit after the edge. If a set event and a clear of the same bit are sampled at the same edge, the bit ends up set.
- R10: Status bits other than 0 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_det | input | 1 | One-cycle pulse per detected horizontal sync |
| vsync_det | input | 1 | One-cycle pulse per detected vertical sync |
| std_sel | input | 1 | Line standard: 0 = 525-line (858 clocks), 1 = 625-line (864 clocks) |
| irq_mask | input | 8 | Interrupt enables; bit 6 no-video, bit 0 vertical sync |
| irq_clr | input | 8 | Write-one-to-clear strobes for the status bits |
| video_present | output | 1 | Video signal present |
| freerun_line | output | 1 | Nominal line pulse generated while absent |
| irq_req | output | 1 | Interrupt request |
| irq_status | output | 8 | Sticky status bits |

## Verification
Two functions can collide at a single edge. A status bit's set event, either a vertical sync or a loss of video, can arrive together with a software clear of that same bit. A horizontal sync can also land on exactly the edge at which the sixteenth missed line would be counted. The bench provokes the first case by driving `vsync_det` and `irq_clr` bit 0 in the same cycle, and judges it by requiring the status bit to stay set. It provokes the second by placing an hsync on the final edge of the loss window, and judges it by requiring the signal to stay present with no no-video flag.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } vstd_e;

    typedef enum logic {
        VP_ABSENT  = 1'b0,
        VP_PRESENT = 1'b1
    } vp_state_e;

    // events produced by the line timer for one cycle
    typedef struct packed {
        logic line_tick;   // a full line elapsed with no hsync
        logic limit_hit;   // this tick completes the missed-line run
    } tmr_evt_t;

    function automatic int unsigned pick_len(vstd_e s, int unsigned len_a,
                                             int unsigned len_b);
        return (s == STD_625) ? len_b : len_a;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vpd_line_timer.sv
module vpd_line_timer
    import vpd_pkg::*;
#(
    parameter int unsigned LEN_A      = 858,
    parameter int unsigned LEN_B      = 864,
    parameter int unsigned MISS_LIMIT = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hsync,
    input  vstd_e    std,
    output tmr_evt_t evt
);
    localparam int unsigned LEN_MAX = max_u(LEN_A, LEN_B);
    localparam int unsigned CNT_W   = $clog2(LEN_MAX);
    localparam int unsigned MISS_W  = $clog2(MISS_LIMIT + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [MISS_W-1:0] miss_q;
    logic [CNT_W-1:0]  len_m1;
    logic              wrap;

    assign len_m1 = CNT_W'(pick_len(std, LEN_A, LEN_B) - 1);
    // >= keeps the timer bounded if the standard shrinks mid-line
    assign wrap   = !hsync && (cnt_q >= len_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            miss_q <= '0;
        end else if (hsync) begin
            cnt_q  <= '0;
            miss_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
            if (miss_q != MISS_W'(MISS_LIMIT))
                miss_q <= miss_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign evt.line_tick = wrap;
    assign evt.limit_hit = wrap && (miss_q == MISS_W'(MISS_LIMIT - 1));

    // R3: missed-line count saturates at the limit
    a_r3_miss_bound: assert property (@(posedge clk) disable iff (rst)
        miss_q <= MISS_W'(MISS_LIMIT));

    // R2: an hsync restarts both the timer and the missed-line count
    a_r2_hs_restart: assert property (@(posedge clk) disable iff (rst)
        hsync |=> (cnt_q == '0) && (miss_q == '0));

    // R4: the timer never runs past the longest line
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(LEN_MAX));

endmodule

// File: rtl/vpd_presence_fsm.sv
module vpd_presence_fsm
    import vpd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hsync,
    input  tmr_evt_t evt,
    output logic     present,
    output logic     freerun,
    output logic     lost_evt
);
    vp_state_e st_q, st_d;
    logic      fr_q;

    always_comb begin
        st_d = st_q;
        if (hsync)
            st_d = VP_PRESENT;
        else if (evt.limit_hit)
            st_d = VP_ABSENT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= VP_ABSENT;
            fr_q <= 1'b0;
        end else begin
            st_q <= st_d;
            fr_q <= evt.line_tick && (st_d == VP_ABSENT);
        end
    end

    assign present  = (st_q == VP_PRESENT);
    assign freerun  = fr_q;
    assign lost_evt = (st_q == VP_PRESENT) && (st_d == VP_ABSENT);

    // R5: free-run pulses only appear while the signal is absent
    a_r5_fr_absent: assert property (@(posedge clk) disable iff (rst)
        fr_q |-> (st_q == VP_ABSENT));

    // R3: loss is only declared on a line tick
    a_r3_loss_on_tick: assert property (@(posedge clk) disable iff (rst)
        (st_q == VP_PRESENT && !hsync && !evt.line_tick) |=> (st_q == VP_PRESENT));

endmodule

// File: rtl/vpd_irq_ctrl.sv
module vpd_irq_ctrl #(
    parameter int unsigned STAT_W = 8,
    parameter int unsigned NV_BIT = 6,
    parameter int unsigned VS_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nv_set,
    input  logic              vs_set,
    input  logic [STAT_W-1:0] mask,
    input  logic [STAT_W-1:0] clr,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);
    localparam logic [STAT_W-1:0] USED = STAT_W'((1 << NV_BIT) | (1 << VS_BIT));

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] stat_q;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (i == NV_BIT) begin : g_nv
            assign set_vec[i] = nv_set;
        end else if (i == VS_BIT) begin : g_vs
            assign set_vec[i] = vs_set;
        end else begin : g_none
            assign set_vec[i] = 1'b0;
        end
        if (i == NV_BIT || i == VS_BIT) begin : g_chk
            // R9: a set sampled together with a clear wins
            a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> stat_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= ((stat_q & ~clr) | set_vec) & USED;
    end

    assign stat = stat_q;
    assign irq  = |(stat_q & mask);

endmodule

// File: rtl/vid_presence_det.sv
module vid_presence_det
    import vpd_pkg::*;
#(
    parameter int unsigned LEN_A      = 858,
    parameter int unsigned LEN_B      = 864,
    parameter int unsigned MISS_LIMIT = 16,
    parameter int unsigned STAT_W     = 8,
    parameter int unsigned NV_BIT     = 6,
    parameter int unsigned VS_BIT     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_det,
    input  logic              vsync_det,
    input  logic              std_sel,
    input  logic [STAT_W-1:0] irq_mask,
    input  logic [STAT_W-1:0] irq_clr,
    output logic              video_present,
    output logic              freerun_line,
    output logic              irq_req,
    output logic [STAT_W-1:0] irq_status
);
    tmr_evt_t evt;
    logic     lost_evt;

    vpd_line_timer #(
        .LEN_A      (LEN_A),
        .LEN_B      (LEN_B),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .hsync (hsync_det),
        .std   (vstd_e'(std_sel)),
        .evt   (evt)
    );

    vpd_presence_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hsync    (hsync_det),
        .evt      (evt),
        .present  (video_present),
        .freerun  (freerun_line),
        .lost_evt (lost_evt)
    );

    vpd_irq_ctrl #(
        .STAT_W (STAT_W),
        .NV_BIT (NV_BIT),
        .VS_BIT (VS_BIT)
    ) u_irq (
        .clk    (clk),
        .rst    (rst),
        .nv_set (lost_evt),
        .vs_set (vsync_det),
        .mask   (irq_mask),
        .clr    (irq_clr),
        .stat   (irq_status),
        .irq    (irq_req)
    );

    // R2: an hsync pulse makes the signal present after the edge
    a_r2_hs_restores: assert property (@(posedge clk) disable iff (rst)
        hsync_det |=> video_present);

    // R6: a drop of video_present is always flagged in the status
    a_r6_loss_flagged: assert property (@(posedge clk) disable iff (rst)
        $fell(video_present) |-> irq_status[NV_BIT]);

    // R7: a vertical sync always sets its status bit
    a_r7_vs_flagged: assert property (@(posedge clk) disable iff (rst)
        vsync_det |=> irq_status[VS_BIT]);

    // R5: the first free-run pulse coincides with the loss
    a_r5_first_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(video_present) |-> freerun_line);

endmodule

// File: tb/vid_presence_det_tb_top.sv
module vid_presence_det_tb_top;
    localparam int LA = 858;
    localparam int LB = 864;
    localparam int ML = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_det = 1'b0;
    logic       vsync_det = 1'b0;
    logic       std_sel = 1'b0;
    logic [7:0] irq_mask = 8'h00;
    logic [7:0] irq_clr = 8'h00;
    logic       video_present, freerun_line, irq_req;
    logic [7:0] irq_status;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vid_presence_det dut_i (
        .clk           (clk),
        .rst           (rst),
        .hsync_det     (hsync_det),
        .vsync_det     (vsync_det),
        .std_sel       (std_sel),
        .irq_mask      (irq_mask),
        .irq_clr       (irq_clr),
        .video_present (video_present),
        .freerun_line  (freerun_line),
        .irq_req       (irq_req),
        .irq_status    (irq_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one hsync pulse; returns just after the edge that sampled it
    task automatic hs();
        @(negedge clk) hsync_det = 1'b1;
        @(posedge clk); #1 hsync_det = 1'b0;
    endtask

    task automatic clr_bits(input logic [7:0] v);
        @(negedge clk) irq_clr = v;
        @(posedge clk); #1 irq_clr = 8'h00;
    endtask

    // edges from the last hsync until video_present falls
    task automatic measure_loss(input int lim, output int k);
        k = 0;
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk); #1;
            if (!video_present) begin k = i; break; end
            if (freerun_line) chk("R5 pulse while present", 1, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk) rst = 1'b0;
        chk("R1 present", video_present, 0);
        chk("R1 status", irq_status, 0);
        chk("R1 irq", irq_req, 0);
        chk("R1 freerun", freerun_line, 0);
        // idle absent from reset for more than the loss window: no flag (R6)
        repeat (ML * LA + 20) @(posedge clk);
        #1 chk("R6 no flag from idle after reset", irq_status[6], 0);
    endtask

    task automatic t_loss_525();
        int k;
        std_sel = 1'b0;
        irq_mask = 8'h00;
        hs();
        chk("R2 present after hsync", video_present, 1);
        measure_loss(ML * LA + 10, k);
        chk("R3/R4 loss edge 525", k, ML * LA);
        chk("R5 first pulse at loss", freerun_line, 1);
        chk("R6 no-video status", irq_status[6], 1);
        chk("R8 irq masked off", irq_req, 0);
        irq_mask = 8'h01; #1;
        chk("R8 wrong mask bit", irq_req, 0);
        irq_mask = 8'h40; #1;
        chk("R8 no-video irq", irq_req, 1);
    endtask

    task automatic t_freerun_625();
        int k;
        int p1, p2, np;
        clr_bits(8'h40);
        chk("R9 clear no-video", irq_status[6], 0);
        chk("R8 irq drops after clear", irq_req, 0);
        std_sel = 1'b1;
        hs();
        measure_loss(ML * LB + 10, k);
        chk("R3/R4 loss edge 625", k, ML * LB);
        p1 = 0; p2 = 0; np = 0;
        for (int i = 1; i <= 2 * LB + 3; i++) begin
            @(posedge clk); #1;
            if (freerun_line) begin
                np++;
                if (np == 1) p1 = i; else if (np == 2) p2 = i;
            end
        end
        chk("R5 pulse count", np, 2);
        chk("R5 first period", p1, LB);
        chk("R5 second period", p2, 2 * LB);
        chk("R5 stays absent", video_present, 0);
    endtask

    task automatic t_no_repeat();
        clr_bits(8'h40);
        repeat (ML * LB + 50) @(posedge clk);
        #1 chk("R6 no re-flag while absent", irq_status[6], 0);
        chk("R8 irq idle", irq_req, 0);
    endtask

    task automatic t_edge_hsync();
        std_sel = 1'b0;
        hs();
        repeat (ML * LA - 1) @(posedge clk);
        #1 chk("R3 present one edge before limit", video_present, 1);
        hs();
        chk("R3 hsync on last edge keeps present", video_present, 1);
        chk("R6 no flag on rescue", irq_status[6], 0);
    endtask

    task automatic t_vsync();
        irq_mask = 8'h00;
        @(negedge clk) vsync_det = 1'b1;
        @(posedge clk); #1 vsync_det = 1'b0;
        chk("R7 vsync status", irq_status[0], 1);
        chk("R8 vsync masked", irq_req, 0);
        irq_mask = 8'h01; #1;
        chk("R8 vsync irq", irq_req, 1);
        clr_bits(8'h01);
        chk("R9 clear vsync", irq_status[0], 0);
        @(negedge clk) begin vsync_det = 1'b1; irq_clr = 8'hFF; end
        @(posedge clk); #1 begin vsync_det = 1'b0; irq_clr = 8'h00; end
        chk("R9 set wins over clear", irq_status[0], 1);
        chk("R10 other bits zero", irq_status & 8'hBE, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_loss_525();
        t_freerun_625();
        t_no_repeat();
        t_edge_hsync();
        t_vsync();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule